// File: doc/BRIEF.md
# Unaligned Access Splitting Bus Unit

This unit sits between a processor core's load/store path and a downstream bus that only accepts naturally aligned, full-width word transactions qualified by byte strobes. The core hands over one access at a time: an address, a size code, a direction, write data and three flags. The flags mark the access as part of a block transfer, as a stack push/pop, or as an exclusive access. The unit answers each access with exactly one response pulse.

An access that fits inside one aligned word goes out as a single beat, with strobes set on just the bytes it touches. An access that runs past the end of a word goes out as two beats, lower word first. Write data is rotated onto the byte lanes. Read data from both beats is joined in little-endian order and returned once the second beat is back. Software sees no difference except the extra cycles.

Some accesses must not be misaligned. These are accesses flagged as block transfers, stack operations or exclusive accesses, and accesses whose address falls in a bit-band alias window. Such an access is refused with a fault response and never reaches the bus. A configuration input turns unaligned support off entirely, and then every misaligned access faults. If the bus reports an error on a beat, the access is aborted.

Top module: `unaligned_split_unit`

## Requirements
- R1: An access whose bytes all lie in one aligned word produces exactly one bus beat. The beat's address has its two low bits zero, and its strobe bit k is set exactly for the bytes at word address plus k that the access covers.
- R2: An access whose bytes cross a word boundary produces two beats. The first beat goes to the lower word and the second to that word plus 4. Each beat strobes only the bytes of the access that lie in its own word.
- R3: Byte i of the write data (bits 8i+7 down to 8i) is placed on lane (offset+i) mod 4 of the beat that holds address+i. Memory then holds the data at the original address.
- R4: The read response carries byte i of the access at bits 8i+7 down to 8i, with all higher bits zero. It is given as a single one-cycle response pulse after the last beat completes. The response data is zero for writes, faults and errors.
- R5: An access is misaligned when its address is not a multiple of its byte count. When cfg_unaligned_en is 0, a misaligned access gets a fault response and issues no beat, while aligned accesses still complete.
- R6: A misaligned access with req_multi set faults and issues no beat. The same flag on an aligned access has no effect.
- R7: A misaligned access with req_stack set faults and issues no beat. The same flag on an aligned access has no effect.
- R8: A misaligned access with req_excl set faults and issues no beat. The same flag on an aligned access has no effect.
- R9: A misaligned access whose address lies in a bit-band alias window faults and issues no beat. The default windows are 0x2200_0000 and 0x4200_0000, each 32 MiB in size. Aligned accesses there complete normally.
- R10: A bus error on the first beat gives an error response, and the second beat is never issued.
- R11: A bus error on the second beat gives an error response. The bytes of the first beat have already been written.
- R12: The size code is 0 for a byte, 1 for a halfword and 2 for a word. Code 3 is reserved and always faults with no beat.
- R13: req_ready is high only when no access is in flight. Beat address, strobes and write data stay stable while bus_valid waits for bus_ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_unaligned_en | input | 1 | 1 allows misaligned accesses to be split |
| req_valid | input | 1 | Core access request |
| req_ready | output | 1 | Unit can accept an access |
| req_addr | input | AW | Byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_write | input | 1 | 1 store, 0 load |
| req_wdata | input | DW | Store data, right-aligned |
| req_multi | input | 1 | Access belongs to a block transfer |
| req_stack | input | 1 | Access is a stack push/pop |
| req_excl | input | 1 | Access is exclusive |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_rdata | output | DW | Load data, right-aligned, zero-extended |
| rsp_err | output | 1 | Downstream error aborted the access |
| rsp_fault | output | 1 | Access refused for alignment |
| bus_valid | output | 1 | Beat request |
| bus_ready | input | 1 | Beat accepted |
| bus_addr | output | AW | Word-aligned beat address |
| bus_write | output | 1 | Beat direction |
| bus_wdata | output | DW | Beat write data |
| bus_strb | output | DW/8 | Byte strobes |
| bus_resp_valid | input | 1 | Beat completion |
| bus_resp_rdata | input | DW | Beat read data |
| bus_resp_err | input | 1 | Beat error |

## Verification
The assertions assume the bus side holds only one beat in flight. They expect bus_resp_valid only after a beat has been accepted and before the next one is issued, which is why an error completion is taken to silence bus_valid in the following cycle. The bench's bus responder keeps to this rule. It waits for each handshake and then returns exactly one completion, after a varying ready delay and latency. The core side presents a new access only after the previous response, and it never injects an error except on a word chosen by the test.

// File: rtl/usu_pkg.sv
package usu_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LO_REQ,
    ST_LO_WAIT,
    ST_HI_REQ,
    ST_HI_WAIT,
    ST_RESP
  } state_e;

endpackage

// File: rtl/usu_rst_sync.sv
module usu_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/usu_decode.sv
// Classifies one incoming access: byte span over two words, split need,
// and whether the alignment rules refuse it.
module usu_decode
  import usu_pkg::*;
#(
  parameter int              AW      = 32,
  parameter int              DW      = 32,
  parameter int              NBB     = 2,
  parameter logic [AW-1:0]   BB_BASE [NBB] = '{32'h2200_0000, 32'h4200_0000},
  parameter logic [AW-1:0]   BB_SPAN = 32'h0200_0000,
  localparam int             LANES   = DW / 8,
  localparam int             OFFW    = $clog2(LANES)
) (
  input  logic [AW-1:0]    addr,
  input  logic [1:0]       size,
  input  logic             cfg_en,
  input  logic             multi,
  input  logic             stack,
  input  logic             excl,
  output logic             fault,
  output logic             split,
  output logic [LANES-1:0] strb_lo,
  output logic [LANES-1:0] strb_hi,
  output logic [AW-1:0]    word_addr,
  output logic [OFFW-1:0]  offs
);

  logic [LANES-1:0]   len_mask;
  logic [2*LANES-1:0] span;
  logic [OFFW-1:0]    align_mask;
  logic [NBB-1:0]     bb_hit;
  logic               size_ok;
  logic               misalign;
  logic               bb_any;
  acc_size_e          sz;

  // one comparator per alias window
  for (genvar g = 0; g < NBB; g++) begin : g_bb
    assign bb_hit[g] = (addr - BB_BASE[g]) < BB_SPAN;
  end

  always_comb begin
    sz         = acc_size_e'(size);
    size_ok    = (sz != SZ_RSVD) && (int'(size) <= OFFW);
    for (int i = 0; i < LANES; i++) begin
      len_mask[i] = (i < (1 << size));
    end
    offs       = addr[OFFW-1:0];
    span       = {{LANES{1'b0}}, len_mask} << offs;
    align_mask = OFFW'((1 << size) - 1);
    misalign   = |(offs & align_mask);
    bb_any     = |bb_hit;
    fault      = !size_ok ||
                 (misalign && (!cfg_en || multi || stack || excl || bb_any));
    strb_lo    = span[LANES-1:0];
    strb_hi    = span[2*LANES-1:LANES];
    split      = |strb_hi;
    word_addr  = {addr[AW-1:OFFW], {OFFW{1'b0}}};
  end

endmodule

// File: rtl/usu_lanes.sv
// Byte-lane steering: rotates store data across two beats and
// gathers load data from two beats back to the right.
module usu_lanes #(
  parameter  int DW    = 32,
  localparam int LANES = DW / 8,
  localparam int OFFW  = $clog2(LANES)
) (
  input  logic [DW-1:0]   wdata,
  input  logic [OFFW-1:0] offs,
  input  logic [1:0]      size,
  input  logic [DW-1:0]   rd_lo,
  input  logic [DW-1:0]   rd_hi,
  output logic [DW-1:0]   wd_lo,
  output logic [DW-1:0]   wd_hi,
  output logic [DW-1:0]   rdata
);

  logic [2*DW-1:0] wr_wide;
  logic [2*DW-1:0] rd_wide;
  logic [OFFW+2:0] shamt;

  always_comb begin
    shamt   = {offs, 3'b000};
    wr_wide = {{DW{1'b0}}, wdata} << shamt;
    wd_lo   = wr_wide[DW-1:0];
    wd_hi   = wr_wide[2*DW-1:DW];
    rd_wide = {rd_hi, rd_lo} >> shamt;
    for (int i = 0; i < LANES; i++) begin
      rdata[8*i +: 8] = (i < (1 << size)) ? rd_wide[8*i +: 8] : 8'h00;
    end
  end

endmodule

// File: rtl/usu_ctrl.sv
// Sequencer: one access in flight, up to two beats, one response cycle.
module usu_ctrl
  import usu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic dec_fault,
  input  logic dec_split,
  input  logic bus_ready,
  input  logic bus_resp_valid,
  input  logic bus_resp_err,
  output logic req_ready,
  output logic req_fire,
  output logic bus_valid,
  output logic beat_hi,
  output logic cap_lo,
  output logic cap_hi,
  output logic rsp_valid,
  output logic fault_q,
  output logic err_q
);

  state_e st_q, st_d;
  logic   split_q, split_d;
  logic   fault_d, err_d;

  always_comb begin
    st_d    = st_q;
    split_d = split_q;
    fault_d = fault_q;
    err_d   = err_q;
    unique case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          split_d = dec_split;
          fault_d = dec_fault;
          err_d   = 1'b0;
          st_d    = dec_fault ? ST_RESP : ST_LO_REQ;
        end
      end
      ST_LO_REQ: begin
        if (bus_ready) st_d = ST_LO_WAIT;
      end
      ST_LO_WAIT: begin
        if (bus_resp_valid) begin
          if (bus_resp_err) begin
            err_d = 1'b1;
            st_d  = ST_RESP;
          end else begin
            st_d  = split_q ? ST_HI_REQ : ST_RESP;
          end
        end
      end
      ST_HI_REQ: begin
        if (bus_ready) st_d = ST_HI_WAIT;
      end
      ST_HI_WAIT: begin
        if (bus_resp_valid) begin
          err_d = bus_resp_err;
          st_d  = ST_RESP;
        end
      end
      ST_RESP: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      split_q <= 1'b0;
      fault_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      split_q <= split_d;
      fault_q <= fault_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign req_fire  = req_ready && req_valid;
  assign bus_valid = (st_q == ST_LO_REQ) || (st_q == ST_HI_REQ);
  assign beat_hi   = (st_q == ST_HI_REQ) || (st_q == ST_HI_WAIT);
  assign cap_lo    = (st_q == ST_LO_WAIT) && bus_resp_valid;
  assign cap_hi    = (st_q == ST_HI_WAIT) && bus_resp_valid;
  assign rsp_valid = (st_q == ST_RESP);

endmodule

// File: rtl/unaligned_split_unit.sv
module unaligned_split_unit #(
  parameter  int            AW      = 32,
  parameter  int            DW      = 32,
  parameter  int            NBB     = 2,
  parameter  logic [AW-1:0] BB_BASE [NBB] = '{32'h2200_0000, 32'h4200_0000},
  parameter  logic [AW-1:0] BB_SPAN = 32'h0200_0000,
  localparam int            LANES   = DW / 8,
  localparam int            OFFW    = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_unaligned_en,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    req_addr,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic [DW-1:0]    req_wdata,
  input  logic             req_multi,
  input  logic             req_stack,
  input  logic             req_excl,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_rdata,
  output logic             rsp_err,
  output logic             rsp_fault,
  output logic             bus_valid,
  input  logic             bus_ready,
  output logic [AW-1:0]    bus_addr,
  output logic             bus_write,
  output logic [DW-1:0]    bus_wdata,
  output logic [LANES-1:0] bus_strb,
  input  logic             bus_resp_valid,
  input  logic [DW-1:0]    bus_resp_rdata,
  input  logic             bus_resp_err
);

  logic             rst_sync_n;
  logic             dec_fault, dec_split;
  logic [LANES-1:0] dec_strb_lo, dec_strb_hi;
  logic [AW-1:0]    dec_word;
  logic [OFFW-1:0]  dec_offs;
  logic             req_fire, beat_hi, cap_lo, cap_hi;
  logic             fault_q, err_q, ctl_rsp;

  logic [AW-1:0]    word_q;
  logic [OFFW-1:0]  offs_q;
  logic [1:0]       size_q;
  logic             write_q;
  logic [DW-1:0]    wdata_q;
  logic [LANES-1:0] strb_lo_q, strb_hi_q;
  logic [DW-1:0]    rd_lo_q, rd_hi_q;
  logic [DW-1:0]    wd_lo, wd_hi, merged;

  usu_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  usu_decode #(
    .AW(AW), .DW(DW), .NBB(NBB), .BB_BASE(BB_BASE), .BB_SPAN(BB_SPAN)
  ) u_dec (
    .addr      (req_addr),
    .size      (req_size),
    .cfg_en    (cfg_unaligned_en),
    .multi     (req_multi),
    .stack     (req_stack),
    .excl      (req_excl),
    .fault     (dec_fault),
    .split     (dec_split),
    .strb_lo   (dec_strb_lo),
    .strb_hi   (dec_strb_hi),
    .word_addr (dec_word),
    .offs      (dec_offs)
  );

  usu_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_sync_n),
    .req_valid      (req_valid),
    .dec_fault      (dec_fault),
    .dec_split      (dec_split),
    .bus_ready      (bus_ready),
    .bus_resp_valid (bus_resp_valid),
    .bus_resp_err   (bus_resp_err),
    .req_ready      (req_ready),
    .req_fire       (req_fire),
    .bus_valid      (bus_valid),
    .beat_hi        (beat_hi),
    .cap_lo         (cap_lo),
    .cap_hi         (cap_hi),
    .rsp_valid      (ctl_rsp),
    .fault_q        (fault_q),
    .err_q          (err_q)
  );

  usu_lanes #(.DW(DW)) u_lanes (
    .wdata (wdata_q),
    .offs  (offs_q),
    .size  (size_q),
    .rd_lo (rd_lo_q),
    .rd_hi (rd_hi_q),
    .wd_lo (wd_lo),
    .wd_hi (wd_hi),
    .rdata (merged)
  );

  // access context, loaded with the accept enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      word_q    <= '0;
      offs_q    <= '0;
      size_q    <= '0;
      write_q   <= 1'b0;
      wdata_q   <= '0;
      strb_lo_q <= '0;
      strb_hi_q <= '0;
    end else if (req_fire) begin
      word_q    <= dec_word;
      offs_q    <= dec_offs;
      size_q    <= req_size;
      write_q   <= req_write;
      wdata_q   <= req_wdata;
      strb_lo_q <= dec_strb_lo;
      strb_hi_q <= dec_strb_hi;
    end
  end

  // beat read capture, each word with its own enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_lo_q <= '0;
    end else if (cap_lo) begin
      rd_lo_q <= bus_resp_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rd_hi_q <= '0;
    end else if (cap_hi) begin
      rd_hi_q <= bus_resp_rdata;
    end else if (req_fire) begin
      rd_hi_q <= '0;
    end
  end

  assign bus_addr  = beat_hi ? (word_q + AW'(LANES)) : word_q;
  assign bus_write = write_q;
  assign bus_wdata = beat_hi ? wd_hi : wd_lo;
  assign bus_strb  = beat_hi ? strb_hi_q : strb_lo_q;

  assign rsp_valid = ctl_rsp;
  assign rsp_fault = ctl_rsp && fault_q;
  assign rsp_err   = ctl_rsp && err_q;
  assign rsp_rdata = (ctl_rsp && !write_q && !fault_q && !err_q) ? merged : '0;

endmodule

// File: rtl/usu_checker.sv
module usu_checker #(
  parameter  int AW    = 32,
  parameter  int DW    = 32,
  localparam int LANES = DW / 8,
  localparam int OFFW  = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             bus_valid,
  input logic             bus_ready,
  input logic [AW-1:0]    bus_addr,
  input logic [LANES-1:0] bus_strb,
  input logic [DW-1:0]    bus_wdata,
  input logic             bus_resp_valid,
  input logic             bus_resp_err,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic             rsp_err,
  input logic [DW-1:0]    rsp_rdata
);

  assert_beat_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> (bus_addr[OFFW-1:0] == '0));

  assert_strb_used_R1: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> ($countones(bus_strb) > 0));

  assert_beat_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_ready) |=>
      (bus_valid && $stable(bus_addr) && $stable(bus_strb) && $stable(bus_wdata)));

  assert_busy_no_ready_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && bus_valid));

  assert_err_stops_beats_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_resp_valid && bus_resp_err) |=> !bus_valid);

  assert_rsp_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_quiet_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && (rsp_fault || rsp_err)) |-> (rsp_rdata == '0));

  assert_one_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !(rsp_fault && rsp_err));

  assert_status_only_rsp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_fault || rsp_err));

endmodule

bind unaligned_split_unit usu_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .req_ready      (req_ready),
  .bus_valid      (bus_valid),
  .bus_ready      (bus_ready),
  .bus_addr       (bus_addr),
  .bus_strb       (bus_strb),
  .bus_wdata      (bus_wdata),
  .bus_resp_valid (bus_resp_valid),
  .bus_resp_err   (bus_resp_err),
  .rsp_valid      (rsp_valid),
  .rsp_fault      (rsp_fault),
  .rsp_err        (rsp_err),
  .rsp_rdata      (rsp_rdata)
);

// File: tb/unaligned_split_unit_test.sv
`timescale 1ns/1ps
module unaligned_split_unit_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_unaligned_en;
  logic        req_valid, req_ready;
  logic [31:0] req_addr;
  logic [1:0]  req_size;
  logic        req_write;
  logic [31:0] req_wdata;
  logic        req_multi, req_stack, req_excl;
  logic        rsp_valid, rsp_err, rsp_fault;
  logic [31:0] rsp_rdata;
  logic        bus_valid, bus_ready, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_strb;
  logic        bus_resp_valid, bus_resp_err;
  logic [31:0] bus_resp_rdata;

  always #5 clk = ~clk;

  unaligned_split_unit uut (
    .clk(clk), .rst_n(rst_n), .cfg_unaligned_en(cfg_unaligned_en),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_size(req_size), .req_write(req_write), .req_wdata(req_wdata),
    .req_multi(req_multi), .req_stack(req_stack), .req_excl(req_excl),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .rsp_fault(rsp_fault), .bus_valid(bus_valid), .bus_ready(bus_ready),
    .bus_addr(bus_addr), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_strb(bus_strb), .bus_resp_valid(bus_resp_valid),
    .bus_resp_rdata(bus_resp_rdata), .bus_resp_err(bus_resp_err)
  );

  typedef struct packed {
    logic [31:0] a;
    logic        w;
    logic [3:0]  s;
    logic [31:0] d;
  } beat_t;

  beat_t       expq[$];
  logic [7:0]  bmem [logic [31:0]];
  logic [7:0]  rmem [logic [31:0]];
  logic [31:0] err_word;
  int          total = 0;
  int          bad   = 0;
  int          nbeat = 0;
  logic        awaiting = 1'b0;

  function automatic logic [7:0] init_b(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] bmem_rd(input logic [31:0] a);
    return bmem.exists(a) ? bmem[a] : init_b(a);
  endfunction

  function automatic logic [7:0] rmem_rd(input logic [31:0] a);
    return rmem.exists(a) ? rmem[a] : init_b(a);
  endfunction

  task automatic check(input logic ok, input string rq,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", rq, act, exp);
    end
  endtask

  // downstream bus model: varying ready delay and completion latency
  initial begin
    beat_t cur, e;
    logic  er;
    logic [31:0] rd;
    bus_ready = 1'b0; bus_resp_valid = 1'b0; bus_resp_err = 1'b0;
    bus_resp_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_valid === 1'b1) begin
        repeat (nbeat % 3) @(negedge clk);
        cur = '{bus_addr, bus_write, bus_strb, bus_wdata};
        bus_ready = 1'b1;
        @(negedge clk);
        bus_ready = 1'b0;
        if (expq.size() == 0) begin
          check(1'b0, "R13 unexpected beat", {32'h0, cur.a}, 64'h0);
        end else begin
          e = expq.pop_front();
          check(cur.a === e.a, "R2 beat address", {32'h0, cur.a}, {32'h0, e.a});
          check(cur.s === e.s, "R1 beat strobes", {60'h0, cur.s}, {60'h0, e.s});
          check(cur.w === e.w, "R1 beat direction", {63'h0, cur.w}, {63'h0, e.w});
          if (e.w) begin
            for (int j = 0; j < 4; j++) begin
              if (e.s[j])
                check(cur.d[8*j +: 8] === e.d[8*j +: 8], "R3 lane data",
                      {56'h0, cur.d[8*j +: 8]}, {56'h0, e.d[8*j +: 8]});
            end
          end
        end
        er = (cur.a == err_word);
        rd = '0;
        for (int j = 0; j < 4; j++) begin
          rd[8*j +: 8] = bmem_rd(cur.a + j);
          if (!er && cur.w && cur.s[j]) bmem[cur.a + j] = cur.d[8*j +: 8];
        end
        repeat (nbeat % 2) @(negedge clk);
        bus_resp_valid = 1'b1; bus_resp_err = er; bus_resp_rdata = rd;
        @(negedge clk);
        bus_resp_valid = 1'b0; bus_resp_err = 1'b0;
        nbeat++;
      end
    end
  end

  // every-cycle monitor: a response only when one is awaited
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1 && !awaiting && rsp_valid !== 1'b0)
        check(1'b0, "R4 spurious response", {63'h0, rsp_valid}, 64'h0);
    end
  end

  task automatic do_access(input logic [31:0] addr, input logic [1:0] size,
                           input logic wr, input logic [31:0] wd,
                           input logic mu, input logic st, input logic ex,
                           input string rq);
    int          nb, lane;
    logic [31:0] lo, hi, a, e_rd, d_lo, d_hi;
    logic [3:0]  s_lo, s_hi;
    logic        flt, e_err, mis, bb, got;
    nb = 1 << size;
    lo = addr & ~32'd3;
    hi = lo + 32'd4;
    s_lo = '0; s_hi = '0; d_lo = '0; d_hi = '0; e_rd = '0; e_err = 1'b0;
    mis = (size == 2'd3) || ((addr % nb) != 0);
    bb  = (addr >= 32'h2200_0000 && addr < 32'h2400_0000) ||
          (addr >= 32'h4200_0000 && addr < 32'h4400_0000);
    flt = (size == 2'd3) ||
          (mis && (!cfg_unaligned_en || mu || st || ex || bb));
    if (!flt) begin
      for (int i = 0; i < nb; i++) begin
        a = addr + i;
        lane = a % 4;
        if ((a & ~32'd3) == lo) begin
          s_lo[lane] = 1'b1; d_lo[8*lane +: 8] = wd[8*i +: 8];
        end else begin
          s_hi[lane] = 1'b1; d_hi[8*lane +: 8] = wd[8*i +: 8];
        end
        if (!wr) e_rd[8*i +: 8] = rmem_rd(a);
      end
      expq.push_back('{lo, wr, s_lo, d_lo});
      if (lo == err_word) e_err = 1'b1;
      else if (s_hi != 0) begin
        expq.push_back('{hi, wr, s_hi, d_hi});
        if (hi == err_word) e_err = 1'b1;
      end
      if (wr) begin
        for (int i = 0; i < nb; i++) begin
          a = addr + i;
          if ((a & ~32'd3) != err_word && !((a & ~32'd3) == hi && lo == err_word))
            rmem[a] = wd[8*i +: 8];
        end
      end
    end
    if (flt || e_err || wr) e_rd = '0;

    @(negedge clk);
    check(req_ready === 1'b1, "R13 ready when idle", {63'h0, req_ready}, 64'h1);
    req_addr = addr; req_size = size; req_write = wr; req_wdata = wd;
    req_multi = mu; req_stack = st; req_excl = ex;
    req_valid = 1'b1; awaiting = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 80 && !got; k++) begin
      if (rsp_valid === 1'b1) got = 1'b1;
      else @(negedge clk);
    end
    check(got, {rq, " response seen"}, {63'h0, got}, 64'h1);
    check(rsp_fault === flt, {rq, " fault flag"}, {63'h0, rsp_fault}, {63'h0, flt});
    check(rsp_err === e_err, {rq, " error flag"}, {63'h0, rsp_err}, {63'h0, e_err});
    check(rsp_rdata === e_rd, {rq, " read data"}, {32'h0, rsp_rdata}, {32'h0, e_rd});
    check(expq.size() == 0, {rq, " all beats issued"}, 64'(expq.size()), 64'h0);
    expq.delete();
    @(negedge clk);
    awaiting = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_unaligned_en = 1'b1; req_valid = 1'b0;
    req_addr = '0; req_size = '0; req_write = 1'b0; req_wdata = '0;
    req_multi = 1'b0; req_stack = 1'b0; req_excl = 1'b0;
    err_word = 32'hFFFF_FFFC;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0 && bus_valid === 1'b0, "R13 reset outputs",
          {62'h0, rsp_valid, bus_valid}, 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(req_ready === 1'b1, "R13 ready after reset", {63'h0, req_ready}, 64'h1);

    // R1: aligned and in-word accesses
    do_access(32'h1000_0000, 2'd2, 1'b1, 32'hDEAD_BEEF, 0, 0, 0, "R1 word write");
    do_access(32'h1000_0000, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R1 word read");
    for (int o = 0; o < 4; o++) begin
      do_access(32'h1000_0010 + o, 2'd0, 1'b1, 32'h11 * (o + 1), 0, 0, 0, "R1 byte write");
      do_access(32'h1000_0010 + o, 2'd0, 1'b0, 32'h0, 0, 0, 0, "R1 byte read");
    end
    do_access(32'h1000_0021, 2'd1, 1'b1, 32'h0000_CAFE, 0, 0, 0, "R1 half in word");
    do_access(32'h1000_0020, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R3 word after half");

    // R2 R3 R4: crossing accesses
    do_access(32'h1000_0033, 2'd1, 1'b1, 32'h0000_A55A, 0, 0, 0, "R2 half split write");
    do_access(32'h1000_0033, 2'd1, 1'b0, 32'h0, 0, 0, 0, "R4 half split read");
    for (int o = 1; o < 4; o++) begin
      do_access(32'h1000_0040 + 8 * o + o, 2'd2, 1'b1, 32'h1234_5678 + o, 0, 0, 0, "R2 word split write");
      do_access(32'h1000_0040 + 8 * o + o, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R4 word split read");
      do_access(32'h1000_0040 + 8 * o, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R3 low word back");
      do_access(32'h1000_0044 + 8 * o, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R3 high word back");
    end

    // R5: unaligned support off
    cfg_unaligned_en = 1'b0;
    do_access(32'h1000_0052, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R5 word fault");
    do_access(32'h1000_0051, 2'd1, 1'b1, 32'h0000_FFFF, 0, 0, 0, "R5 half fault");
    do_access(32'h1000_0050, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R5 memory untouched");
    do_access(32'h1000_0052, 2'd1, 1'b1, 32'h0000_7777, 0, 0, 0, "R5 aligned half ok");
    cfg_unaligned_en = 1'b1;

    // R6 R7 R8: access kinds that forbid misalignment
    do_access(32'h1000_0061, 2'd2, 1'b1, 32'hFFFF_FFFF, 1, 0, 0, "R6 multi fault");
    do_access(32'h1000_0060, 2'd2, 1'b1, 32'h6666_6666, 1, 0, 0, "R6 multi aligned");
    do_access(32'h1000_0063, 2'd1, 1'b0, 32'h0, 0, 1, 0, "R7 stack fault");
    do_access(32'h1000_0064, 2'd2, 1'b1, 32'h7777_0000, 0, 1, 0, "R7 stack aligned");
    do_access(32'h1000_0066, 2'd2, 1'b0, 32'h0, 0, 0, 1, "R8 excl fault");
    do_access(32'h1000_0062, 2'd1, 1'b0, 32'h0, 0, 0, 1, "R8 excl aligned");
    do_access(32'h1000_0060, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R6 memory check");

    // R9: bit-band alias windows
    do_access(32'h2200_0001, 2'd1, 1'b1, 32'h0000_0001, 0, 0, 0, "R9 alias half fault");
    do_access(32'h2200_0004, 2'd2, 1'b1, 32'h0000_0001, 0, 0, 0, "R9 alias word ok");
    do_access(32'h4200_0003, 2'd0, 1'b0, 32'h0, 0, 0, 0, "R9 alias byte ok");
    do_access(32'h4200_0006, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R9 alias word fault");
    do_access(32'h21FF_FFFE, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R9 below window split");

    // R10: error on the first beat
    err_word = 32'h1000_0100;
    do_access(32'h1000_0102, 2'd2, 1'b1, 32'hBAD0_BAD0, 0, 0, 0, "R10 low beat error");
    do_access(32'h1000_0103, 2'd1, 1'b0, 32'h0, 0, 0, 0, "R10 low beat read error");
    err_word = 32'hFFFF_FFFC;
    do_access(32'h1000_0104, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R10 high word untouched");

    // R11: error on the second beat
    err_word = 32'h1000_0204;
    do_access(32'h1000_0203, 2'd2, 1'b1, 32'hC0DE_F00D, 0, 0, 0, "R11 high beat error");
    err_word = 32'hFFFF_FFFC;
    do_access(32'h1000_0200, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R11 low bytes written");

    // R12: reserved size code
    do_access(32'h1000_0300, 2'd3, 1'b0, 32'h0, 0, 0, 0, "R12 reserved size");
    do_access(32'h1000_0300, 2'd3, 1'b1, 32'h1, 0, 0, 0, "R12 reserved size write");

    // mixed patterns across offsets and sizes
    for (int i = 0; i < 24; i++) begin
      do_access(32'h1000_0400 + 5 * i, 2'(i % 3), 1'(i % 2 == 0),
                32'h9E37_79B9 * (i + 1), 0, 0, 0, "R2 mixed access");
    end
    for (int i = 0; i < 12; i++) begin
      do_access(32'h1000_0400 + 4 * i, 2'd2, 1'b0, 32'h0, 0, 0, 0, "R3 mixed readback");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule